// File: doc/BRIEF.md
# Framer Performance Monitor Counter Bank

This block keeps the receive-side error and event tallies for a single DS1 or E1 framer channel. The framer sends it one-cycle strobes as frames and sub-multiframes arrive, along with two alignment flags and a line-mode select. The bank turns these strobes into increments for five saturating 16-bit counters. Each increment is gated by the alignment condition that makes that measurement meaningful.

Software or a supervising block reads one counter at a time through an index-and-enable port. The value appears on `rd_data` one clock later. The counter that was read is cleared by the same read. An event that lands in the reading cycle is kept, so a clearing read never loses an event.

Top module: `pm_counter_bank`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a rising edge) sets all five counters and `rd_data` to zero.
- R2: Counter indices are 0 = frame errors, 1 = CRC errors, 2 = E-bit-zero events, 3 = Sa6 00x1 events, 4 = Sa6 001x events. A read with `rd_en` = 1 places the selected counter's value, before that cycle's event, on `rd_data` at the next edge. `rd_data` holds its value between reads. An index of 5 to 7 returns 0 and clears nothing.
- R3: A read clears the counter it selects. If that counter has an increment in the same cycle, it holds the increment after the read.
- R4: Each counter saturates at 0xFFFF and never wraps.
- R5: In DS1 mode (`e1_mode` = 0), a frame error strobe adds one only while `frm_aligned` = 1. In DS1 mode the NOTFAS, E-bit and Sa6 inputs have no effect.
- R6: In E1 mode, a FAS error strobe with `fas_err_nbits` ≥ 1 adds exactly one to the frame counter, whatever the number of bad bits. A count of 0 adds nothing. E1 FAS counting is not gated by `frm_aligned`.
- R7: In E1 mode with `notfas_cnt_en` = 1, a NOTFAS strobe with `notfas_bit2` = 0 adds one to the frame counter. When `notfas_cnt_en` = 0, or when `notfas_bit2` = 1, the strobe adds nothing. A FAS error and a NOTFAS error in the same cycle add two.
- R8: A CRC error strobe adds one only while `mf_aligned` = 1, in either mode.
- R9: In E1 mode, an E-bit strobe with `ebit_val` = 0 adds one only while `mf_aligned` = 1. `ebit_val` = 1 adds nothing.
- R10: In E1 mode, while `mf_aligned` = 1, an Sa6 strobe decodes `sa6_nib`. Bit 3 holds the first-received bit. The pattern 0,0,x,1 (bit 3 to bit 0) adds one to counter 3. The pattern 0,0,1,x adds one to counter 4. A nibble of 0011 adds one to both. No Sa5 input takes part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e1_mode | input | 1 | 1 = E1 line, 0 = DS1 line |
| notfas_cnt_en | input | 1 | E1: also count NOTFAS bit-2 errors |
| frm_aligned | input | 1 | Frame alignment held |
| mf_aligned | input | 1 | CRC multiframe alignment held |
| fas_err_stb | input | 1 | Framing bit / FAS word checked this cycle |
| fas_err_nbits | input | 3 | Number of bits found in error |
| notfas_stb | input | 1 | NOTFAS word received |
| notfas_bit2 | input | 1 | Received bit 2 of that NOTFAS word |
| crc_err_stb | input | 1 | CRC check failed |
| ebit_stb | input | 1 | E bit received |
| ebit_val | input | 1 | Value of that E bit |
| sa6_stb | input | 1 | Sa6 nibble complete for a sub-multiframe |
| sa6_nib | input | 4 | Sa6 nibble, bit 3 first received |
| rd_en | input | 1 | Read and clear request |
| rd_idx | input | 3 | Counter index |
| rd_data | output | 16 | Read value, valid the cycle after `rd_en` |

## Verification
Counter state is visible only through reads. A wrong gate, a wrong decode or a missed saturation stays hidden until the affected counter is read. It then shows as a wrong value exactly one edge after `rd_en`. A second read straight after shows whether the clear worked.

The reference model therefore predicts `rd_data` on every clock, not only after reads. Tests read each counter soon after stimulating it, so a fault is pinned to the few cycles that caused it.

// File: rtl/pm_pkg.sv
// Shared constants and counter indices for the performance monitor bank.
// Assumes five counters; the index values are visible at the read port.
package pm_pkg;
    localparam int NUM_CNT = 5;
    localparam int IDX_W   = 3;
    localparam int INC_W   = 2;   // up to two events per cycle per counter

    typedef enum logic [IDX_W-1:0] {
        CNT_FRM   = 3'd0,
        CNT_CRC   = 3'd1,
        CNT_EBIT  = 3'd2,
        CNT_SA6_A = 3'd3,
        CNT_SA6_B = 3'd4
    } cnt_idx_e;
endpackage

// File: rtl/pm_event_decode.sv
// Turns framer strobes into per-counter increment amounts.
// Applies the mode and alignment gates and the Sa6 pattern decode.
// Assumes every strobe is a single-cycle pulse and inputs are synchronous.
module pm_event_decode
    import pm_pkg::*;
#(
    parameter int FAS_W = 7,
    localparam int NB_W = $clog2(FAS_W + 1)
) (
    input  logic                             e1_mode,
    input  logic                             notfas_cnt_en,
    input  logic                             frm_aligned,
    input  logic                             mf_aligned,
    input  logic                             fas_err_stb,
    input  logic [NB_W-1:0]                  fas_err_nbits,
    input  logic                             notfas_stb,
    input  logic                             notfas_bit2,
    input  logic                             crc_err_stb,
    input  logic                             ebit_stb,
    input  logic                             ebit_val,
    input  logic                             sa6_stb,
    input  logic [3:0]                       sa6_nib,
    output logic [NUM_CNT-1:0][INC_W-1:0]    inc_vec
);
    logic fas_hit;
    logic notfas_hit;
    logic e1_mf_ok;
    logic sa6_a_hit;
    logic sa6_b_hit;

    // Qualify raw strobes into single-event hits.
    always_comb begin
        fas_hit    = fas_err_stb && (fas_err_nbits != '0);
        notfas_hit = e1_mode && notfas_cnt_en && notfas_stb && !notfas_bit2;
        e1_mf_ok   = e1_mode && mf_aligned;
        sa6_a_hit  = (sa6_nib[3:2] == 2'b00) && sa6_nib[0];
        sa6_b_hit  = (sa6_nib[3:1] == 3'b001);
    end

    // Form the increment amount for each counter.
    always_comb begin
        inc_vec = '0;
        if (e1_mode)
            inc_vec[CNT_FRM] = {1'b0, fas_hit} + {1'b0, notfas_hit};
        else
            inc_vec[CNT_FRM] = {1'b0, fas_hit && frm_aligned};
        inc_vec[CNT_CRC]   = {1'b0, crc_err_stb && mf_aligned};
        inc_vec[CNT_EBIT]  = {1'b0, e1_mf_ok && ebit_stb && !ebit_val};
        inc_vec[CNT_SA6_A] = {1'b0, e1_mf_ok && sa6_stb && sa6_a_hit};
        inc_vec[CNT_SA6_B] = {1'b0, e1_mf_ok && sa6_stb && sa6_b_hit};
    end
endmodule

// File: rtl/pm_sat_counter.sv
// One saturating counter with clear-on-read.
// A clear in the same cycle as an increment leaves the increment value.
// Assumes INC_W is smaller than CNT_W.
module pm_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W:0] sum;

    // Widened sum so that overflow shows in the top bit.
    always_comb sum = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};

    // Update the count: reset, clear with carry-in, saturate or add.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= {{(CNT_W - INC_W){1'b0}}, inc};
        else if (sum[CNT_W])
            cnt <= '1;
        else
            cnt <= sum[CNT_W-1:0];
    end
endmodule

// File: rtl/pm_read_port.sv
// Index-selected read port with one cycle of latency.
// Issues the clear for the selected counter; an out-of-range index reads zero.
// Assumes at most one read per cycle.
module pm_read_port
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
    output logic [NUM_CNT-1:0]            clr_vec,
    output logic [CNT_W-1:0]              rd_data
);
    logic [CNT_W-1:0] sel_val;

    // Decode one clear line per counter.
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_clr
        assign clr_vec[i] = rd_en && (rd_idx == IDX_W'(i));
    end

    // Select the addressed count; zero when no counter matches.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_idx == IDX_W'(i)) sel_val = cnt_vec[i];
    end

    // Register the read value; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= sel_val;
    end
endmodule

// File: rtl/pm_counter_bank.sv
// Performance monitor counter bank for one DS1/E1 receive channel.
// Decodes framer strobes, keeps five saturating clear-on-read counters,
// and serves indexed reads. Assumes all inputs are synchronous to clk.
module pm_counter_bank
    import pm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FAS_W = 7,
    localparam int NB_W = $clog2(FAS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e1_mode,
    input  logic             notfas_cnt_en,
    input  logic             frm_aligned,
    input  logic             mf_aligned,
    input  logic             fas_err_stb,
    input  logic [NB_W-1:0]  fas_err_nbits,
    input  logic             notfas_stb,
    input  logic             notfas_bit2,
    input  logic             crc_err_stb,
    input  logic             ebit_stb,
    input  logic             ebit_val,
    input  logic             sa6_stb,
    input  logic [3:0]       sa6_nib,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data
);
    logic [NUM_CNT-1:0][INC_W-1:0] inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CNT-1:0]            clr_vec;

    pm_event_decode #(.FAS_W(FAS_W)) u_dec (
        .e1_mode       (e1_mode),
        .notfas_cnt_en (notfas_cnt_en),
        .frm_aligned   (frm_aligned),
        .mf_aligned    (mf_aligned),
        .fas_err_stb   (fas_err_stb),
        .fas_err_nbits (fas_err_nbits),
        .notfas_stb    (notfas_stb),
        .notfas_bit2   (notfas_bit2),
        .crc_err_stb   (crc_err_stb),
        .ebit_stb      (ebit_stb),
        .ebit_val      (ebit_val),
        .sa6_stb       (sa6_stb),
        .sa6_nib       (sa6_nib),
        .inc_vec       (inc_vec)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pm_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[i]),
            .clr   (clr_vec[i]),
            .cnt   (cnt_vec[i])
        );
    end

    pm_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .cnt_vec (cnt_vec),
        .clr_vec (clr_vec),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pm_counter_bank_chk.sv
// Assertion checker for pm_counter_bank, attached by bind below.
// Observes ports plus the decode, counter and read-port interconnect.
module pm_counter_bank_chk
    import pm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          e1_mode,
    input logic                          notfas_cnt_en,
    input logic                          frm_aligned,
    input logic                          mf_aligned,
    input logic                          notfas_stb,
    input logic                          rd_en,
    input logic [IDX_W-1:0]              rd_idx,
    input logic [CNT_W-1:0]              rd_data,
    input logic [NUM_CNT-1:0][INC_W-1:0] inc_vec,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
    input logic [NUM_CNT-1:0]            clr_vec
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && cnt_vec == '0)); // R1

    AST_BAD_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx >= IDX_W'(NUM_CNT)) |=> rd_data == '0); // R2

    AST_DS1_LOF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!e1_mode && !frm_aligned) |-> inc_vec[CNT_FRM] == '0); // R5

    AST_FAS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_mode && !(notfas_cnt_en && notfas_stb)) |-> inc_vec[CNT_FRM] <= 2'd1); // R6

    AST_CRC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_aligned |-> inc_vec[CNT_CRC] == '0); // R8

    AST_EBIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mf_aligned || !e1_mode) |-> inc_vec[CNT_EBIT] == '0); // R9

    AST_SA6_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mf_aligned || !e1_mode) |->
            (inc_vec[CNT_SA6_A] == '0 && inc_vec[CNT_SA6_B] == '0)); // R10

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_per
        AST_CLR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |=> cnt_vec[i] == CNT_W'($past(inc_vec[i]))); // R3

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_vec[i] == '1 && !clr_vec[i]) |=> cnt_vec[i] == '1); // R4

        AST_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_vec[i] |=> cnt_vec[i] >= $past(cnt_vec[i])); // R3
    end
endmodule

bind pm_counter_bank pm_counter_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .e1_mode       (e1_mode),
    .notfas_cnt_en (notfas_cnt_en),
    .frm_aligned   (frm_aligned),
    .mf_aligned    (mf_aligned),
    .notfas_stb    (notfas_stb),
    .rd_en         (rd_en),
    .rd_idx        (rd_idx),
    .rd_data       (rd_data),
    .inc_vec       (inc_vec),
    .cnt_vec       (cnt_vec),
    .clr_vec       (clr_vec)
);

// File: tb/tb_pm_counter_bank.sv
// Bench: behavioural reference model, rd_data compared after every clock.
module tb_pm_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = 65535;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        e1_mode, notfas_cnt_en, frm_aligned, mf_aligned;
    logic        fas_err_stb, notfas_stb, notfas_bit2, crc_err_stb;
    logic        ebit_stb, ebit_val, sa6_stb, rd_en;
    logic [2:0]  fas_err_nbits, rd_idx;
    logic [3:0]  sa6_nib;
    logic [15:0] rd_data;

    int    model [5];
    int    exp_rd;
    int    checks = 0;
    int    errors = 0;
    string req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    pm_counter_bank dut (
        .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .notfas_cnt_en(notfas_cnt_en),
        .frm_aligned(frm_aligned), .mf_aligned(mf_aligned),
        .fas_err_stb(fas_err_stb), .fas_err_nbits(fas_err_nbits),
        .notfas_stb(notfas_stb), .notfas_bit2(notfas_bit2),
        .crc_err_stb(crc_err_stb), .ebit_stb(ebit_stb), .ebit_val(ebit_val),
        .sa6_stb(sa6_stb), .sa6_nib(sa6_nib),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic idle();
        fas_err_stb = 0; fas_err_nbits = 0; notfas_stb = 0; notfas_bit2 = 1;
        crc_err_stb = 0; ebit_stb = 0; ebit_val = 1; sa6_stb = 0; sa6_nib = 0;
        rd_en = 0; rd_idx = 0;
    endtask

    // Predict the next state from the present inputs, clock, then compare.
    task automatic tick();
        int inc [5];
        if (!rst_n) begin
            foreach (model[i]) model[i] = 0;
            exp_rd = 0;
        end else begin
            inc[0] = 0;
            if (e1_mode) begin
                if (fas_err_stb && fas_err_nbits != 0) inc[0]++;
                if (notfas_cnt_en && notfas_stb && !notfas_bit2) inc[0]++;
            end else if (fas_err_stb && fas_err_nbits != 0 && frm_aligned) inc[0] = 1;
            inc[1] = (crc_err_stb && mf_aligned) ? 1 : 0;
            inc[2] = (e1_mode && mf_aligned && ebit_stb && !ebit_val) ? 1 : 0;
            inc[3] = (e1_mode && mf_aligned && sa6_stb && !sa6_nib[3] && !sa6_nib[2]
                      && sa6_nib[0]) ? 1 : 0;
            inc[4] = (e1_mode && mf_aligned && sa6_stb && sa6_nib[3:1] == 3'b001) ? 1 : 0;
            if (rd_en) exp_rd = (rd_idx < 5) ? model[rd_idx] : 0;
            for (int i = 0; i < 5; i++) begin
                if (rd_en && rd_idx == i) model[i] = inc[i];
                else model[i] = (model[i] + inc[i] > MAXV) ? MAXV : model[i] + inc[i];
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (int'(rd_data) != exp_rd) begin
            errors++;
            $display("FAIL %s: rd_data actual %0d expected %0d at %0t", req, rd_data, exp_rd, $time);
        end
        @(negedge clk);
    endtask

    task automatic rd(input int idx);
        rd_en = 1; rd_idx = 3'(idx);
        tick();
        rd_en = 0;
        tick();
    endtask

    task automatic rd_all();
        for (int i = 0; i < 5; i++) rd(i);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; e1_mode = 0; notfas_cnt_en = 0; frm_aligned = 1; mf_aligned = 1;
        @(negedge clk);
        req = "R1";
        tick(); tick();
        rst_n = 1;
        rd_all();

        // R5: DS1 counting, loss of frame gate, E1-only inputs ignored
        req = "R5";
        for (int i = 0; i < 5; i++) begin
            fas_err_stb = 1; fas_err_nbits = 1; tick();
        end
        frm_aligned = 0;
        for (int i = 0; i < 3; i++) begin
            fas_err_stb = 1; fas_err_nbits = 1; tick();
        end
        idle(); frm_aligned = 1;
        notfas_cnt_en = 1; notfas_stb = 1; notfas_bit2 = 0; ebit_stb = 1; ebit_val = 0;
        sa6_stb = 1; sa6_nib = 4'b0011; tick(); idle();
        rd_all();

        // R6: E1 FAS multi-bit errors count once, zero-bit count ignored
        req = "R6";
        e1_mode = 1; notfas_cnt_en = 0; frm_aligned = 0;
        for (int n = 0; n < 8; n++) begin
            fas_err_stb = 1; fas_err_nbits = 3'(n); tick();
        end
        idle(); rd(0);

        // R7: NOTFAS bit 2 counting and its enable
        req = "R7";
        frm_aligned = 1;
        notfas_stb = 1; notfas_bit2 = 0; tick(); tick();
        notfas_bit2 = 1; tick();
        notfas_cnt_en = 1; notfas_bit2 = 0; tick(); tick();
        notfas_bit2 = 1; tick();
        notfas_bit2 = 0; fas_err_stb = 1; fas_err_nbits = 7; tick();
        idle(); rd(0); rd(0);

        // R8: CRC gate in both modes
        req = "R8";
        for (int m = 0; m < 2; m++) begin
            e1_mode = m[0];
            mf_aligned = 1; crc_err_stb = 1; tick(); tick(); tick();
            mf_aligned = 0; tick(); tick();
            idle(); mf_aligned = 1; rd(1);
        end

        // R9: E bit zero events
        req = "R9";
        ebit_stb = 1; ebit_val = 0; tick(); tick();
        ebit_val = 1; tick();
        ebit_val = 0; mf_aligned = 0; tick();
        idle(); mf_aligned = 1; rd(2);

        // R10: Sa6 nibble sweep, aligned and not aligned
        req = "R10";
        for (int v = 0; v < 16; v++) begin
            sa6_stb = 1; sa6_nib = 4'(v); tick();
            sa6_stb = 0; tick();
        end
        rd(3); rd(4);
        mf_aligned = 0;
        for (int v = 0; v < 16; v++) begin
            sa6_stb = 1; sa6_nib = 4'(v); tick();
        end
        idle(); mf_aligned = 1; rd(3); rd(4);

        // R3: event coinciding with the clearing read is kept
        req = "R3";
        crc_err_stb = 1; tick(); tick();
        rd_en = 1; rd_idx = 1; tick();
        idle(); tick(); rd(1); rd(1);
        sa6_stb = 1; sa6_nib = 4'b0011; tick();
        rd_en = 1; rd_idx = 4; tick();
        idle(); rd(3); rd(4); rd(4);

        // R2: out-of-range index reads zero and clears nothing
        req = "R2";
        ebit_stb = 1; ebit_val = 0; tick(); tick(); idle();
        rd(5); rd(6); rd(7); rd(2);

        // R4: saturation at the top value
        req = "R4";
        e1_mode = 0; frm_aligned = 1;
        fas_err_stb = 1; fas_err_nbits = 1;
        for (int i = 0; i < MAXV + 10; i++) tick();
        idle(); rd(0); rd(0);

        // R1: reset mid-run clears everything
        req = "R1";
        crc_err_stb = 1; tick(); idle();
        rst_n = 0; tick(); rst_n = 1;
        rd_all();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule